// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-clock static RAM with registered inputs and a registered output stage. An access starts when the address strobe is low and all three chip enables are at their active levels. The sampled address becomes the start of a four-beat burst, and an internal 2-bit counter steps through the beats whenever the advance input is low. The beat order is either interleaved or linear, chosen by a mode input. Read data leaves the output register one clock after the edge that sampled the command. Writes take effect on the sampling edge, either on all lanes through a global write enable or on a chosen set of byte lanes.

Because three enables are decoded, several copies of the block can share one address bus for depth expansion. A start command with any enable inactive deselects the block, and its output drive goes away one edge later. A sleep input freezes every register, memory included, until it falls again. The output enable acts on the drive without waiting for the clock. The shared data bus is modelled as separate in, out and drive-enable signals.

Top module: `syncBurstSram`

## Requirements
- R1: Every register changes only on the rising clock edge. Read data for a command sampled at edge k is driven after edge k+1 (one pipeline stage), with dOe high and dOut equal to the word stored at the beat address when the command was sampled.
- R2: With adsN low and the block selected (selA low, selB high, selC low), addrIn is loaded as the burst start and the beat count is reset to 0.
- R3: With adsN high during an active burst, advN low steps the beat count by one, wrapping modulo 4. advN high keeps the same beat address.
- R4: With burstLinear low (interleaved order), the low two bits of the beat address are start[1:0] XOR count, and the upper bits equal the start address.
- R5: With burstLinear high (linear order), the low two bits are (start[1:0] + count) mod 4, with no carry into the upper bits.
- R6: When byteWrEnN is low and globalWrN is high, each lane i whose laneWrN[i] is low stores dIn[i*LANE_W +: LANE_W], and the other lanes keep their contents. If no lane strobe is low, the beat is a read.
- R7: globalWrN low writes every lane, whatever byteWrEnN and laneWrN say.
- R8: A write beat produces no output drive: dOe stays low in the cycle its pipeline slot reaches the output.
- R9: adsN low with any enable inactive ends the burst. dOe is low after the next edge, and advN has no effect until a new selected start.
- R10: While sleep is high, commands are ignored, no register or memory word changes, and dOut and dOe hold their values.
- R11: outEnN high forces dOe low at once, without a clock edge. When outEnN is low, dOe follows the internal drive.
- R12: rstN low clears the burst and the output drive (dOe low). Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset of control and output stage, active low |
| addrIn | input | ADDR_W | Word address sampled on a start |
| selA | input | 1 | Chip enable, active low |
| selB | input | 1 | Chip enable, active high |
| selC | input | 1 | Chip enable, active low |
| adsN | input | 1 | Address strobe, active low: starts or deselects |
| advN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enable per-lane writes, active low |
| laneWrN | input | LANES | Per-lane write strobes, active low |
| burstLinear | input | 1 | Burst order: 0 interleaved, 1 linear |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Freeze all state while high |
| dIn | input | DATA_W | Write data |
| dOut | output | DATA_W | Read data (zero when not driven) |
| dOe | output | 1 | Data bus drive enable |

## Verification
On every cycle, assertions check how the control state responds to a start, a deselect and an advance. They also check that sleep freezes the counter and the output stage, that a write never fills the read pipeline, and that outEnN high keeps the drive off. Only the bench's scenarios show that the right data comes back. That covers the exact beat addresses of both burst orders for every start address, lane-masked writes, the deselect and sleep sequences, and memory that survives a reset. The bench checks these against a reference array that it updates arithmetically.

// File: rtl/sramPkg.sv
package sramPkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic stall;
  } ctrlStrobe_t;

  typedef enum logic {
    BURST_INTERLEAVED = 1'b0,
    BURST_LINEAR      = 1'b1
  } burstOrder_e;
endpackage

// File: rtl/sramBurstSeq.sv
module sramBurstSeq
  import sramPkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        beatCnt,
  input  burstOrder_e       order,
  output logic [ADDR_W-1:0] beatAddr
);
  logic [1:0] lowBits;

  always_comb begin
    if (order == BURST_LINEAR) lowBits = 2'(startAddr[1:0] + beatCnt);
    else                       lowBits = startAddr[1:0] ^ beatCnt;
  end

  assign beatAddr = {startAddr[ADDR_W-1:2], lowBits};
endmodule

// File: rtl/sramBurstCtrl.sv
module sramBurstCtrl
  import sramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selA,
  input  logic              selB,
  input  logic              selC,
  input  logic              adsN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstLinear,
  input  logic              sleep,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] beatAddr,
  output logic [LANES-1:0]  laneMask
);
  logic [ADDR_W-1:0] baseAddr, effBase;
  logic [1:0]        cnt, effCnt;
  logic              active, effActive;
  logic              selected, wrAll, wrSome, anyWr;

  assign selected = !selA && selB && !selC;

  always_comb begin
    if (!adsN) begin
      effActive = selected;
      effBase   = addrIn;
      effCnt    = 2'd0;
    end else begin
      effActive = active;
      effBase   = baseAddr;
      effCnt    = 2'(cnt + {1'b0, !advN});
    end
  end

  sramBurstSeq #(.ADDR_W(ADDR_W)) u_seq (
    .startAddr(effBase),
    .beatCnt  (effCnt),
    .order    (burstOrder_e'(burstLinear)),
    .beatAddr (beatAddr)
  );

  assign wrAll  = !globalWrN;
  assign wrSome = !byteWrEnN && (|(~laneWrN));
  assign anyWr  = wrAll || wrSome;

  assign laneMask     = wrAll ? {LANES{1'b1}} : ~laneWrN;
  assign strobe.wrEn  = effActive && !sleep && anyWr;
  assign strobe.rdEn  = effActive && !sleep && !anyWr;
  assign strobe.stall = sleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      cnt      <= 2'd0;
      active   <= 1'b0;
    end else if (!sleep) begin
      baseAddr <= effBase;
      cnt      <= effCnt;
      active   <= effActive;
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !adsN && selected) |=> (active && cnt == 2'd0 && baseAddr == $past(addrIn)));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && adsN && !advN && active) |=> (cnt == 2'($past(cnt) + 2'd1)));

  // R9
  deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleep && !adsN && !selected) |=> !active);

  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(cnt) && $stable(baseAddr) && $stable(active)));
endmodule

// File: rtl/sramDatapath.sv
module sramDatapath
  import sramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] beatAddr,
  input  logic [LANES-1:0]  laneMask,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDrive
);
  localparam int LANE_W = DATA_W / LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] rdAddrReg;
  logic              rdPend;
  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wrEn && laneMask[g])
        laneMem[beatAddr] <= dIn[g*LANE_W +: LANE_W];
    end

    assign rdWord[g*LANE_W +: LANE_W] = laneMem[rdAddrReg];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPend    <= 1'b0;
      rdAddrReg <= '0;
      rdData    <= '0;
      rdDrive   <= 1'b0;
    end else if (!strobe.stall) begin
      rdPend    <= strobe.rdEn;
      rdAddrReg <= beatAddr;
      rdData    <= rdWord;
      rdDrive   <= rdPend;
    end
  end

  // R1
  rd_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stall && strobe.rdEn) |=> rdPend);

  // R8
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.stall && strobe.wrEn) |=> !rdPend);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stall |=> ($stable(rdData) && $stable(rdDrive)));
endmodule

// File: rtl/syncBurstSram.sv
module syncBurstSram
  import sramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selA,
  input  logic              selB,
  input  logic              selC,
  input  logic              adsN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstLinear,
  input  logic              outEnN,
  input  logic              sleep,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);
  ctrlStrobe_t       strobe;
  logic [ADDR_W-1:0] beatAddr;
  logic [LANES-1:0]  laneMask;
  logic [DATA_W-1:0] rdData;
  logic              rdDrive;

  sramBurstCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn),
    .selA(selA), .selB(selB), .selC(selC),
    .adsN(adsN), .advN(advN), .globalWrN(globalWrN),
    .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .burstLinear(burstLinear), .sleep(sleep),
    .strobe(strobe), .beatAddr(beatAddr), .laneMask(laneMask)
  );

  sramDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .beatAddr(beatAddr),
    .laneMask(laneMask), .dIn(dIn), .rdData(rdData), .rdDrive(rdDrive)
  );

  assign dOe  = rdDrive && !outEnN;
  assign dOut = dOe ? rdData : '0;

  // R11
  oe_async_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dOe);
endmodule

// File: tb/syncBurstSram_tb.sv
module syncBurstSram_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int NL = 2;
  localparam int LW = DW / NL;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          selA = 1'b0, selB = 1'b1, selC = 1'b0;
  logic          adsN = 1'b1, advN = 1'b1;
  logic          globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [NL-1:0] laneWrN = '1;
  logic          burstLinear = 1'b0, outEnN = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic          dOe;

  always #4 clk = ~clk;

  syncBurstSram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) u_dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selA(selA), .selB(selB), .selC(selC),
    .adsN(adsN), .advN(advN), .globalWrN(globalWrN), .byteWrEnN(byteWrEnN),
    .laneWrN(laneWrN), .burstLinear(burstLinear), .outEnN(outEnN), .sleep(sleep),
    .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  int total = 0, fails = 0;
  bit finished = 1'b0;

  // reference state
  logic [DW-1:0] refMem [1<<AW];
  logic [AW-1:0] mBase = '0, pAddr = '0;
  logic [1:0]    mCnt = '0;
  logic          mActive = 1'b0, pOe = 1'b0, eOe = 1'b0;
  logic [DW-1:0] eD = '0;

  task automatic modelEdge();
    logic          sel, eA, wrAll, wrSome, nOe;
    logic [AW-1:0] eB, beat;
    logic [1:0]    eC, lo;
    logic [DW-1:0] nD;
    if (!rstN) begin
      mActive = 1'b0; mCnt = '0; mBase = '0; pOe = 1'b0; pAddr = '0; eOe = 1'b0; eD = '0;
      return;
    end
    if (sleep) return;
    nOe = pOe;
    nD  = refMem[pAddr];
    sel = !selA && selB && !selC;
    if (!adsN) begin eA = sel; eB = addrIn; eC = 2'd0; end
    else begin eA = mActive; eB = mBase; eC = 2'(mCnt + (advN ? 2'd0 : 2'd1)); end
    lo   = burstLinear ? 2'(eB[1:0] + eC) : (eB[1:0] ^ eC);
    beat = {eB[AW-1:2], lo};
    wrAll  = !globalWrN;
    wrSome = !byteWrEnN && (laneWrN != '1);
    if (eA && (wrAll || wrSome))
      for (int l = 0; l < NL; l++)
        if (wrAll || !laneWrN[l]) refMem[beat][l*LW +: LW] = dIn[l*LW +: LW];
    pOe = eA && !(wrAll || wrSome);
    pAddr = beat;
    mActive = eA; mBase = eB; mCnt = eC;
    eOe = nOe; eD = nD;
  endtask

  task automatic checkOut(input string tag);
    logic expDrive;
    expDrive = eOe && !outEnN;
    total++;
    if (dOe !== expDrive || (expDrive && dOut !== eD)) begin
      fails++;
      $display("FAIL %s: dOe=%0b dOut=%h expected dOe=%0b dOut=%h", tag, dOe, dOut, expDrive, eD);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic idle();
    adsN = 1'b1; advN = 1'b1; globalWrN = 1'b1; byteWrEnN = 1'b1; laneWrN = '1;
    selA = 1'b0; selB = 1'b1; selC = 1'b0;
  endtask

  task automatic startBeat(input logic [AW-1:0] a, input string tag);
    idle(); adsN = 1'b0; addrIn = a; step(tag); idle();
  endtask

  task automatic advBeat(input string tag);
    idle(); advN = 1'b0; step(tag); idle();
  endtask

  task automatic flush(input string tag);
    idle(); step(tag); step(tag);
  endtask

  function automatic logic [DW-1:0] pattern(input int a, input int salt);
    return 16'((a * 16'h0105) ^ (salt * 16'h3A71) ^ 16'h5AC3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: run hung, actual=expired expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    modelEdge();
    checkOut("R12 reset drive off");
    rstN = 1'b1;
    @(negedge clk);

    // R7: fill every word with a global write, lane strobes held inactive
    for (int a = 0; a < (1 << AW); a++) begin
      idle(); adsN = 1'b0; addrIn = AW'(a); globalWrN = 1'b0; dIn = pattern(a, 1);
      step("R7 global fill / R8 no drive"); idle();
    end
    flush("R8");

    // R1 R2: single reads of every word
    for (int a = 0; a < (1 << AW); a++) startBeat(AW'(a), "R1 R2 single read");
    flush("R1");

    // R4 R5: full bursts from every start, both orders
    for (int m = 0; m < 2; m++) begin
      burstLinear = m[0];
      for (int a = 0; a < (1 << AW); a++) begin
        startBeat(AW'(a), m == 0 ? "R4 interleaved start" : "R5 linear start");
        for (int b = 0; b < 4; b++) advBeat(m == 0 ? "R4 interleaved beat" : "R5 linear beat/R3 wrap");
      end
      flush("R4 R5");
    end

    // R3: advance held off repeats the same beat
    burstLinear = 1'b1;
    startBeat(6'd13, "R3 hold start");
    advBeat("R3 step");
    step("R3 hold"); step("R3 hold");
    advBeat("R3 step after hold");
    flush("R3");

    // R6: lane-masked writes in a burst, all strobe patterns
    for (int p = 0; p < 4; p++) begin
      idle(); adsN = 1'b0; addrIn = AW'(8 + 4*p); byteWrEnN = 1'b0; laneWrN = NL'(p);
      dIn = pattern(p, 7); step("R6 byte write start"); idle();
      for (int b = 0; b < 3; b++) begin
        idle(); advN = 1'b0; byteWrEnN = 1'b0; laneWrN = NL'(p); dIn = pattern(b + 4*p, 9);
        step("R6 byte write beat"); idle();
      end
      flush("R6");
      for (int w = 0; w < 4; w++) startBeat(AW'(8 + 4*p + w), "R6 byte readback");
      flush("R6");
    end

    // R7: global write wins over inactive byte enables
    idle(); adsN = 1'b0; addrIn = 6'd40; globalWrN = 1'b0; byteWrEnN = 1'b0; laneWrN = 2'b10;
    dIn = 16'hBEEF; step("R7 global override"); idle();
    flush("R7"); startBeat(6'd40, "R7 readback"); flush("R7");

    // R9: deselect by each enable in turn, advance ignored afterwards
    for (int e = 0; e < 3; e++) begin
      startBeat(6'd20, "R9 start");
      advBeat("R9 beat");
      idle(); adsN = 1'b0; addrIn = 6'd33;
      if (e == 0) selA = 1'b1; else if (e == 1) selB = 1'b0; else selC = 1'b1;
      step("R9 deselect edge"); idle();
      step("R9 single-cycle deselect");
      advBeat("R9 advance ignored"); advBeat("R9 advance ignored");
      flush("R9");
    end

    // R10: sleep freezes everything
    burstLinear = 1'b0;
    startBeat(6'd50, "R10 start");
    advBeat("R10 beat");
    sleep = 1'b1;
    for (int s = 0; s < 6; s++) begin
      idle(); adsN = 1'b0; addrIn = AW'(48 + s); globalWrN = 1'b0; dIn = 16'hDEAD;
      step("R10 sleeping holds output"); idle();
    end
    sleep = 1'b0;
    advBeat("R10 resume beat"); advBeat("R10 resume beat");
    flush("R10");
    for (int s = 0; s < 6; s++) startBeat(AW'(48 + s), "R10 memory kept");
    flush("R10");

    // R11: output enable acts without a clock
    startBeat(6'd5, "R11 start");
    idle(); step("R11 data out");
    #1 outEnN = 1'b1; #1;
    total++;
    if (dOe !== 1'b0) begin fails++; $display("FAIL R11: dOe=%0b expected 0", dOe); end
    outEnN = 1'b0; #1;
    total++;
    if (dOe !== 1'b1 || dOut !== refMem[5]) begin
      fails++; $display("FAIL R11: dOe=%0b dOut=%h expected 1 %h", dOe, dOut, refMem[5]);
    end
    @(negedge clk);
    flush("R11");

    // R12: reset mid-burst, memory retained
    startBeat(6'd60, "R12 start");
    rstN = 1'b0; #1; modelEdge(); checkOut("R12 reset clears drive");
    @(negedge clk); rstN = 1'b1;
    advBeat("R12 no burst after reset");
    flush("R12");
    for (int a = 56; a < 64; a++) startBeat(AW'(a), "R12 memory retained");
    flush("R12");

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule